// File: doc/BRIEF.md
# 3x3 Window Gather over a Multiplexed Memory Bus

This block collects the nine pixels of a 3x3 neighbourhood around a chosen centre pixel. It reaches image memory through one 24-bit bus that carries an address in one cycle and data in a later cycle. The fetch makes one read transaction per window row, three rows in all. In each address phase the block places the row's base address on the upper bits of the bus. It places three 2-bit column offsets on the lower bits, one offset for each pixel of that row. It then raises the read strobe and captures the three pixels that memory returns together.

A caller presents the centre coordinates and the image line width, then pulses `start`. Six cycles later the nine pixel registers hold the window in raster order and `done` pulses. While a fetch is running, further start requests are dropped. The pixel registers keep their contents until the next fetch overwrites them, so a consumer can read them at any time after `done`.

Top module: `nbrWindowFetch`

## Requirements
- R1: While `rstN` is low, and after reset until the first start, `pixOut`, `done`, `busOe`, `addrStb`, `rdStb` and `busOut` are all zero.
- R2: In every address phase, `busOe` and `addrStb` are high and `rdStb` is low. The low six bits of `busOut` are 6'b100100: bits [1:0]=00 select the left pixel, bits [3:2]=01 the centre pixel and bits [5:4]=10 the right pixel. The code 11 never appears.
- R3: Each address phase is followed in the very next cycle by a read phase, in which `rdStb` is high and `busOe` and `addrStb` are low. `addrStb` and `rdStb` are never high together.
- R4: Rows are fetched top, middle, bottom. The upper 18 bits of `busOut` for row r (0..2) equal (centreY*lineWidth + centreX + (r-1)*lineWidth - 1) modulo 2^18, so consecutive row bases differ by `lineWidth`.
- R5: In a read phase, `busIn` bits [7:0], [15:8] and [23:16] carry the pixels at offsets 00, 01 and 10. They are stored in slot row*3+col, and slot k appears on `pixOut[8k+7:8k]`.
- R6: The first cycle after start is accepted is the row-0 address phase. `done` is high for exactly one cycle, the cycle after the row-2 read phase, which is the seventh cycle after the accepting edge. At that point all nine slots hold the new window.
- R7: A `start` that arrives while a fetch is in progress has no effect. The running fetch keeps the coordinates it began with, and no address phase follows its `done`.
- R8: `pixOut` changes only at the clock edge that ends a read phase. It holds its value at all other times, including while the block is idle.
- R9: A `start` presented in the cycle in which `done` is high is accepted, and the next fetch begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a window fetch; sampled only when idle |
| centreX | input | 9 | Column of the window centre |
| centreY | input | 9 | Row of the window centre |
| lineWidth | input | 10 | Pixels per image line |
| busOut | output | 24 | Bus value driven in the address phase (row base, three offsets) |
| busOe | output | 1 | Block drives the shared bus |
| addrStb | output | 1 | Address strobe; memory latches `busOut` |
| rdStb | output | 1 | Read strobe; memory returns three pixels on `busIn` |
| busIn | input | 24 | Data returned by memory during the read phase |
| pixOut | output | 72 | Nine captured pixels, slot k in bits [8k+7:8k] |
| done | output | 1 | One-cycle pulse when the window is complete |

## Verification
The row-step assertion assumes that `lineWidth` stays constant from the accepting edge until `done`. The bench changes the width only between fetches. The other assertions assume only that memory returns data in the same cycle as `rdStb`. The bench's responder latches the address on `addrStb` and drives the three pixels combinationally while `rdStb` is high. It honours each offset field, so an offset that is encoded wrongly shows up as a wrong pixel. The sweep covers every centre in a 4x4 corner, including the wrapping top-left border, at three line widths. It mixes back-to-back starts, idle gaps and starts injected mid-fetch.

// File: rtl/nbrFetchPkg.sv
package nbrFetchPkg;
  localparam int ROWS  = 3;
  localparam int COLS  = 3;
  localparam int OFS_W = 2;
  localparam int SLOTS = ROWS * COLS;
  localparam int ROW_W = 2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             loadCentre;
    logic             driveAddr;
    logic             readEn;
    logic [ROW_W-1:0] rowIdx;
  } fetchStrobe_t;
endpackage

// File: rtl/nbrFetchCtrl.sv
module nbrFetchCtrl
  import nbrFetchPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output fetchStrobe_t strobes,
  output logic         done
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_READ} fetchState_t;

  fetchState_t      state;
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      rowCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state  <= S_ADDR;
            rowCnt <= '0;
          end
        end
        S_ADDR: state <= S_READ;
        S_READ: begin
          if (rowCnt == ROW_W'(ROWS - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            rowCnt <= rowCnt + 1'b1;
            state  <= S_ADDR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadCentre = (state == S_IDLE) && start;
    strobes.driveAddr  = (state == S_ADDR);
    strobes.readEn     = (state == S_READ);
    strobes.rowIdx     = rowCnt;
  end
endmodule

// File: rtl/nbrFetchPath.sv
module nbrFetchPath
  import nbrFetchPkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int COORD_W = 9,
  parameter int LW_W    = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fetchStrobe_t             strobes,
  input  logic [COORD_W-1:0]       centreX,
  input  logic [COORD_W-1:0]       centreY,
  input  logic [LW_W-1:0]          lineWidth,
  input  logic [COLS*PIX_W-1:0]    busIn,
  output logic [COLS*PIX_W-1:0]    busOut,
  output logic [SLOTS*PIX_W-1:0]   pixOut
);
  localparam int BUS_W    = COLS * PIX_W;
  localparam int OFS_BITS = COLS * OFS_W;
  localparam int BASE_W   = BUS_W - OFS_BITS;

  logic [BASE_W-1:0]   rowBase;
  logic [LW_W-1:0]     lwReg;
  logic [BASE_W-1:0]   centreAddr;
  logic [OFS_BITS-1:0] ofsPattern;

  // column offsets: field c carries code c (left, centre, right)
  for (genvar c = 0; c < COLS; c++) begin : gOfs
    assign ofsPattern[c*OFS_W +: OFS_W] = OFS_W'(c);
  end

  assign centreAddr = BASE_W'(centreY) * BASE_W'(lineWidth) + BASE_W'(centreX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBase <= '0;
      lwReg   <= '0;
    end else if (strobes.loadCentre) begin
      rowBase <= centreAddr - BASE_W'(lineWidth) - BASE_W'(1);
      lwReg   <= lineWidth;
    end else if (strobes.readEn) begin
      rowBase <= rowBase + BASE_W'(lwReg);
    end
  end

  assign busOut = strobes.driveAddr ? {rowBase, ofsPattern} : '0;

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    logic [PIX_W-1:0] pixReg;
    always_ff @(posedge clk) begin
      if (!rstN)
        pixReg <= '0;
      else if (strobes.readEn && strobes.rowIdx == ROW_W'(s / COLS))
        pixReg <= busIn[(s % COLS)*PIX_W +: PIX_W];
    end
    assign pixOut[s*PIX_W +: PIX_W] = pixReg;
  end
endmodule

// File: rtl/nbrWindowFetch.sv
module nbrWindowFetch
  import nbrFetchPkg::*;
#(
  parameter  int PIX_W   = 8,
  parameter  int COORD_W = 9,
  parameter  int LW_W    = 10,
  localparam int BUS_W   = COLS * PIX_W,
  localparam int PIX_ALL = SLOTS * PIX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] centreX,
  input  logic [COORD_W-1:0] centreY,
  input  logic [LW_W-1:0]    lineWidth,
  output logic [BUS_W-1:0]   busOut,
  output logic               busOe,
  output logic               addrStb,
  output logic               rdStb,
  input  logic [BUS_W-1:0]   busIn,
  output logic [PIX_ALL-1:0] pixOut,
  output logic               done
);
  fetchStrobe_t strobes;

  nbrFetchCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  nbrFetchPath #(.PIX_W(PIX_W), .COORD_W(COORD_W), .LW_W(LW_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .centreX   (centreX),
    .centreY   (centreY),
    .lineWidth (lineWidth),
    .busIn     (busIn),
    .busOut    (busOut),
    .pixOut    (pixOut)
  );

  assign busOe   = strobes.driveAddr;
  assign addrStb = strobes.driveAddr;
  assign rdStb   = strobes.readEn;
endmodule

// File: rtl/nbrWindowFetchChk.sv
module nbrWindowFetchChk
  import nbrFetchPkg::*;
#(
  parameter  int PIX_W    = 8,
  parameter  int LW_W     = 10,
  localparam int BUS_W    = COLS * PIX_W,
  localparam int OFS_BITS = COLS * OFS_W,
  localparam int BASE_W   = BUS_W - OFS_BITS
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [LW_W-1:0]        lineWidth,
  input logic [BUS_W-1:0]       busOut,
  input logic                   busOe,
  input logic                   addrStb,
  input logic                   rdStb,
  input logic [SLOTS*PIX_W-1:0] pixOut,
  input logic                   done
);
  logic [BASE_W-1:0]   baseBits;
  logic [OFS_BITS-1:0] ofsBits;
  assign baseBits = busOut[BUS_W-1:OFS_BITS];
  assign ofsBits  = busOut[OFS_BITS-1:0];

  assert_offsets_R2: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (addrStb && !rdStb && ofsBits == OFS_BITS'(6'b100100)));

  assert_read_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrStb |=> (rdStb && !busOe && !addrStb));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(addrStb && rdStb));

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addrStb && $past(rdStb)) |-> (baseBits == $past(baseBits, 2) + BASE_W'(lineWidth)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(rdStb));

  assert_pix_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |=> $stable(pixOut));
endmodule

bind nbrWindowFetch nbrWindowFetchChk #(.PIX_W(PIX_W), .LW_W(LW_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .lineWidth (lineWidth),
  .busOut    (busOut),
  .busOe     (busOe),
  .addrStb   (addrStb),
  .rdStb     (rdStb),
  .pixOut    (pixOut),
  .done      (done)
);

// File: tb/sim_nbrWindowFetch.sv
`timescale 1ns/1ps
module sim_nbrWindowFetch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  centreX = '0;
  logic [8:0]  centreY = '0;
  logic [9:0]  lineWidth = 10'd5;
  logic [23:0] busOut;
  logic        busOe;
  logic        addrStb;
  logic        rdStb;
  logic [23:0] busIn;
  logic [71:0] pixOut;
  logic        done;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  nbrWindowFetch u0 (
    .clk(clk), .rstN(rstN), .start(start), .centreX(centreX), .centreY(centreY),
    .lineWidth(lineWidth), .busOut(busOut), .busOe(busOe), .addrStb(addrStb),
    .rdStb(rdStb), .busIn(busIn), .pixOut(pixOut), .done(done)
  );

  // image content as a function of address
  function automatic logic [7:0] pixAt(input logic [17:0] a);
    logic [31:0] t;
    t = {14'b0, a} * 32'd2654435761;
    return t[23:16] ^ t[7:0];
  endfunction

  // synchronous memory responder
  logic [23:0] memAddr = '0;
  always @(posedge clk) if (addrStb) memAddr <= busOut;
  always_comb begin
    busIn = '0;
    if (rdStb)
      for (int i = 0; i < 3; i++)
        busIn[i*8 +: 8] = pixAt(memAddr[23:6] + 18'(memAddr[2*i +: 2]));
  end

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFetch(input int cx, input int cy, input int w, input bit glitch);
    logic [71:0] expPix;
    int base;
    expPix = '0;
    centreX = 9'(cx); centreY = 9'(cy); lineWidth = 10'(w);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 3; r++) begin
      base = (cy*w + cx + (r-1)*w - 1) & 32'h3ffff;
      check(busOe && addrStb && !rdStb && busOut[5:0] == 6'b100100, "R2 address phase",
            {48'b0, busOut}, {48'b0, 18'(base), 6'b100100});
      check(busOut[23:6] == 18'(base), "R4 row base", {54'b0, busOut[23:6]}, {54'b0, 18'(base)});
      if (glitch && r == 1) begin
        start = 1'b1; centreX = 9'(cx + 7); centreY = 9'(cy + 3);
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(rdStb && !busOe && !addrStb && !done, "R3 read phase",
            {69'b0, rdStb, busOe, addrStb}, {69'b0, 3'b100});
      for (int c = 0; c < 3; c++) expPix[(r*3+c)*8 +: 8] = pixAt(18'(base + c));
      if (r < 2) begin @(posedge clk); @(negedge clk); end
    end
    @(posedge clk); @(negedge clk);
    check(done == 1'b1, "R6 done pulse", {71'b0, done}, 72'd1);
    check(pixOut == expPix, glitch ? "R7 window kept despite mid start" : "R5 window contents",
          pixOut, expPix);
  endtask

  task automatic idleCheck(input string req);
    logic [71:0] held;
    held = pixOut;
    @(posedge clk); @(negedge clk);
    check(!done, "R6 done one cycle", {71'b0, done}, 72'd0);
    check(!busOe && !addrStb && !rdStb, req, {69'b0, busOe, addrStb, rdStb}, 72'd0);
    check(pixOut == held, "R8 pixels held", pixOut, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int widths [3] = '{5, 17, 300};
    repeat (3) @(negedge clk);
    start = 1'b1;  // ignored under reset
    @(negedge clk);
    check(pixOut == '0 && !done && !busOe && !addrStb && !rdStb && busOut == '0,
          "R1 reset state", pixOut, 72'd0);
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(pixOut == '0 && !done && !busOe && !addrStb && !rdStb && busOut == '0,
          "R1 idle after reset", {48'b0, busOut}, 72'd0);
    foreach (widths[k]) begin
      for (int cy = 0; cy < 4; cy++) begin
        for (int cx = 0; cx < 4; cx++) begin
          bit glitch;
          glitch = (cx == 2);
          doFetch(cx, cy, widths[k], glitch);
          if (glitch) idleCheck("R7 no extra fetch");
          else if (cx % 2 == 1) idleCheck("R8 idle bus quiet");
          // otherwise the next doFetch starts in the done cycle (R9)
        end
      end
      idleCheck("R8 idle between widths");
    end
    // explicit R9: back-to-back fetch begins right after done
    doFetch(9, 6, 40, 1'b0);
    doFetch(10, 6, 40, 1'b0);
    idleCheck("R9 back-to-back end");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule